// File: doc/BRIEF.md
# Serial Clock and Chip-Select Frame Timer

This block produces the serial clock, the active-low chip select and a pair of single-cycle strobes for a serial-memory controller. A neighbouring shift register uses the strobes: one tells it when to capture the incoming bit and the other tells it when to put out the next bit. The block does not move any data itself. It sets out when each edge happens. That covers the clock divider, the clock polarity and phase, three programmable delays, and the rule that decides when chip select is released.

A controller starts each transfer with a one-cycle start strobe. The block asserts chip select. It waits the setup delay and then runs the programmed number of bit periods. After that it either keeps chip select asserted, with a gap before the next transfer is allowed, or it releases chip select and holds it high for a minimum time. Which of these it does depends on the chip-select mode, the last-transfer strobe and an explicit release strobe. A busy flag is high for the whole time the block cannot accept a start.

The block takes its configuration only while it is idle with chip select deasserted. A transfer therefore never sees its settings change part-way through.

Top module: `spi_frame_timer`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0, and busy_o, sample_o and shift_o are 0.
- R2: The SCK period is P = max(cfg_div, 2) system cycles. In each bit the first half lasts floor(P/2) cycles and the second half lasts P - floor(P/2) cycles.
- R3: Outside the bit periods, sck_o rests at cfg_cpol. sck_o differs from the latched polarity only while cs_n_o is 0.
- R4: With cfg_cpha = 0, sample_o pulses on the edge that leaves the idle level and shift_o pulses on the edge that returns to it. With cfg_cpha = 1 the roles are swapped. Each strobe is high in the cycle in which sck_o first shows the new level, and the two strobes are never high together.
- R5: Starting from idle, the first SCK edge comes D cycles after cs_n_o falls when cfg_cpha = 1, and D + floor(P/2) cycles after it falls when cfg_cpha = 0. D is the setup delay field.
- R6: When chip select stays asserted after a transfer, busy_o stays high for G more cycles after the last bit period. G is the between-transfers delay field.
- R7: Whenever chip select is released, cs_n_o stays 1 and busy_o stays 1 for C cycles before a new start is accepted. C is the deselect delay field.
- R8: cfg_cs_mode chooses the release rule. In mode 0, chip select is released only by release_i while the block is holding, and last_i is ignored. In mode 1, chip select is released at the end of a transfer during which last_i was seen (including the start cycle), or by last_i or release_i while holding. In mode 2 or 3, chip select is released after every transfer.
- R9: A transfer lasts n = cfg_nbits + 8 bit periods and has 2n SCK edges.
- R10: A delay field that is 0 stands for floor(P/2) cycles.
- R11: Configuration inputs are taken only while the block is idle with chip select deasserted. Changes made at any other time have no effect on sck_o or on the timing until the next idle period.
- R12: start_i is ignored while busy_o is 1. A start received while chip select is being held begins the bit periods at once, with no setup delay.
- R13: Each transfer gives n sample strobes. It gives n - 1 shift strobes with cfg_cpha = 0 and n with cfg_cpha = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 8 | Baud divisor, system cycles per SCK period |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Capture edge select |
| cfg_nbits | input | 4 | Bits per transfer minus 8 |
| cfg_dly_sck | input | 8 | Chip-select-to-first-edge delay |
| cfg_dly_xfer | input | 8 | Gap after a transfer when CS is kept |
| cfg_dly_csh | input | 8 | Minimum chip-select-high time |
| cfg_cs_mode | input | 2 | Chip-select release rule |
| start_i | input | 1 | Begin one transfer |
| last_i | input | 1 | Mark the final transfer (mode 1) |
| release_i | input | 1 | Release a held chip select |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| sample_o | output | 1 | Capture strobe for the shift register |
| shift_o | output | 1 | Launch strobe for the shift register |
| busy_o | output | 1 | Start cannot be accepted |

## Verification
Single transfers are run with even, odd and clamped divisors (0 and 1), in all four polarity and phase combinations, and with both the shortest and the longest frame size. Together these separate a wrong half-period split, a wrong edge role and a wrong edge count. Zero and non-zero delay fields are mixed so that the half-period default can be told apart from a literal count. Back-to-back transfers in modes 0 and 1 show the held chip select, the skipped setup delay, the ignored last strobe in mode 0, and the release caused by last_i or release_i. A start pulsed in the middle of a transfer and a polarity change made while chip select is held show that neither is acted on at the wrong time.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int DIV_W  = 8;
  localparam int DLY_W  = 8;
  localparam int NB_W   = 4;
  localparam int NB_OFS = 8;
  localparam int HALF_W = $clog2(2 * ((1 << NB_W) - 1 + NB_OFS));
  localparam int CNT_W  = (DLY_W > DIV_W) ? DLY_W : DIV_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_BITS, ST_GAP, ST_HOLD, ST_CSH
  } st_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             cpol;
    logic             cpha;
    logic [NB_W-1:0]  nbits;
    logic [DLY_W-1:0] d_sck;
    logic [DLY_W-1:0] d_xfer;
    logic [DLY_W-1:0] d_csh;
    logic [1:0]       mode;
  } cfg_t;

  // SCK period in system cycles; the divisor is clamped to 2.
  function automatic logic [CNT_W-1:0] sck_period(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(2)) ? CNT_W'(2) : CNT_W'(d);
  endfunction

  function automatic logic [CNT_W-1:0] half_a(input logic [CNT_W-1:0] p);
    return p >> 1;
  endfunction

  function automatic logic [CNT_W-1:0] half_b(input logic [CNT_W-1:0] p);
    return p - (p >> 1);
  endfunction

  // A delay field of zero means half an SCK period.
  function automatic logic [CNT_W-1:0] delay_len(input logic [DLY_W-1:0] d,
                                                 input logic [CNT_W-1:0] p);
    return (d == '0) ? half_a(p) : CNT_W'(d);
  endfunction

  function automatic logic [HALF_W-1:0] half_count(input logic [NB_W-1:0] nb);
    return HALF_W'(2 * (int'(nb) + NB_OFS));
  endfunction
endpackage

// File: rtl/sft_cfg_hold.sv
module sft_cfg_hold
  import sft_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  cfg_t cfg_in,
  output cfg_t cfg_q,
  output cfg_t cfg_eff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (take) cfg_q <= cfg_in;
  end

  assign cfg_eff = take ? cfg_in : cfg_q;

  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cfg_q));
endmodule

// File: rtl/sft_seg_cnt.sv
module sft_seg_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len - W'(1);
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sft_sck_gen.sv
module sft_sck_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic cur_bits,
  input  logic nxt_bits,
  input  logic nxt_half_b,
  input  logic cpol,
  input  logic cpha,
  output logic sck_o,
  output logic sample_o,
  output logic shift_o
);
  logic sck_n, edge_n, lead_n;

  always_comb begin
    sck_n  = cpol ^ (nxt_bits & (nxt_half_b ^ cpha));
    edge_n = (sck_n != sck_o) & (cur_bits | nxt_bits);
    lead_n = (sck_n != cpol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_o    <= 1'b0;
      sample_o <= 1'b0;
      shift_o  <= 1'b0;
    end else begin
      sck_o    <= sck_n;
      sample_o <= edge_n & (lead_n ^ cpha);
      shift_o  <= edge_n & (lead_n == cpha) & nxt_bits;
    end
  end

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && shift_o));
endmodule

// File: rtl/spi_frame_timer.sv
module spi_frame_timer
  import sft_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [NB_W-1:0]  cfg_nbits,
  input  logic [DLY_W-1:0] cfg_dly_sck,
  input  logic [DLY_W-1:0] cfg_dly_xfer,
  input  logic [DLY_W-1:0] cfg_dly_csh,
  input  logic [1:0]       cfg_cs_mode,
  input  logic             start_i,
  input  logic             last_i,
  input  logic             release_i,
  output logic             sck_o,
  output logic             cs_n_o,
  output logic             sample_o,
  output logic             shift_o,
  output logic             busy_o
);
  cfg_t cfg_in, cfg_q, ecfg;
  st_e  st, nst;
  logic [HALF_W-1:0] h, nh, nhalf;
  logic [CNT_W-1:0]  per, la, lb, ldv;
  logic pend, pend_n, ld, seg_last, take, rel_end, mode1;

  assign cfg_in = '{div: cfg_div, cpol: cfg_cpol, cpha: cfg_cpha, nbits: cfg_nbits,
                    d_sck: cfg_dly_sck, d_xfer: cfg_dly_xfer, d_csh: cfg_dly_csh,
                    mode: cfg_cs_mode};
  assign take  = (st == ST_IDLE);
  assign per   = sck_period(ecfg.div);
  assign la    = half_a(per);
  assign lb    = half_b(per);
  assign nhalf = half_count(ecfg.nbits);
  assign mode1 = (ecfg.mode == 2'd1);

  sft_cfg_hold u_cfg (.clk(clk), .rst_n(rst_n), .take(take), .cfg_in(cfg_in),
                      .cfg_q(cfg_q), .cfg_eff(ecfg));

  sft_seg_cnt #(.W(CNT_W)) u_cnt (.clk(clk), .rst_n(rst_n), .load(ld),
                                  .len(ldv), .last(seg_last));

  always_comb begin
    nst     = st;
    nh      = h;
    ld      = 1'b0;
    ldv     = CNT_W'(1);
    pend_n  = pend;
    rel_end = ecfg.mode[1] | (mode1 & (pend | last_i));
    case (st)
      ST_IDLE: if (start_i) begin
        nst = ST_SETUP; ld = 1'b1; ldv = delay_len(ecfg.d_sck, per); pend_n = last_i;
      end
      ST_SETUP: begin
        pend_n = pend | last_i;
        if (seg_last) begin nst = ST_BITS; nh = '0; ld = 1'b1; ldv = la; end
      end
      ST_BITS: begin
        pend_n = pend | last_i;
        if (seg_last) begin
          ld = 1'b1;
          if (h == nhalf - HALF_W'(1)) begin
            nst = rel_end ? ST_CSH : ST_GAP;
            ldv = rel_end ? delay_len(ecfg.d_csh, per) : delay_len(ecfg.d_xfer, per);
          end else begin
            nh  = h + HALF_W'(1);
            ldv = h[0] ? la : lb;
          end
        end
      end
      ST_GAP: begin
        pend_n = pend | last_i;
        if (seg_last) begin
          if (mode1 & pend_n) begin
            nst = ST_CSH; ld = 1'b1; ldv = delay_len(ecfg.d_csh, per);
          end else nst = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (start_i) begin
          nst = ST_BITS; nh = '0; ld = 1'b1; ldv = la; pend_n = last_i;
        end else if (release_i | (mode1 & last_i)) begin
          nst = ST_CSH; ld = 1'b1; ldv = delay_len(ecfg.d_csh, per);
        end
      end
      ST_CSH: if (seg_last) nst = ST_IDLE;
      default: nst = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      h      <= '0;
      pend   <= 1'b0;
      cs_n_o <= 1'b1;
      busy_o <= 1'b0;
    end else begin
      st     <= nst;
      h      <= nh;
      pend   <= pend_n;
      cs_n_o <= (nst == ST_IDLE) || (nst == ST_CSH);
      busy_o <= (nst != ST_IDLE) && (nst != ST_HOLD);
    end
  end

  sft_sck_gen u_sck (.clk(clk), .rst_n(rst_n), .cur_bits(st == ST_BITS),
                     .nxt_bits(nst == ST_BITS), .nxt_half_b(nh[0]),
                     .cpol(ecfg.cpol), .cpha(ecfg.cpha), .sck_o(sck_o),
                     .sample_o(sample_o), .shift_o(shift_o));

  assert_sck_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o != cfg_q.cpol) |-> !cs_n_o);
  assert_setup_no_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (sck_o == cfg_q.cpol) && busy_o);
  assert_release_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> busy_o);
endmodule

// File: tb/spi_frame_timer_tb.sv
module spi_frame_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg_div = 8'd4, cfg_dly_sck = 8'd1, cfg_dly_xfer = 8'd1, cfg_dly_csh = 8'd1;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [3:0] cfg_nbits = 4'd0;
  logic [1:0] cfg_cs_mode = 2'd2;
  logic start_i = 1'b0, last_i = 1'b0, release_i = 1'b0;
  logic sck_o, cs_n_o, sample_o, shift_o, busy_o;

  int checks = 0, fails = 0;
  int cyc = 0, n_tog, n_samp, n_shift, n_bad, n_busy, n_csl, t_first, t_cs, t_last;
  int iv_min, iv_max;
  logic prev_sck, prev_cs, exp_cpol, exp_cpha;

  always #10 clk = ~clk;

  spi_frame_timer u_dut (.clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_nbits(cfg_nbits), .cfg_dly_sck(cfg_dly_sck),
    .cfg_dly_xfer(cfg_dly_xfer), .cfg_dly_csh(cfg_dly_csh), .cfg_cs_mode(cfg_cs_mode),
    .start_i(start_i), .last_i(last_i), .release_i(release_i), .sck_o(sck_o),
    .cs_n_o(cs_n_o), .sample_o(sample_o), .shift_o(shift_o), .busy_o(busy_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_tog = 0; n_samp = 0; n_shift = 0; n_bad = 0; n_busy = 0; n_csl = 0;
    t_first = -1; t_cs = -1; t_last = 0; iv_min = 1000; iv_max = 0;
    prev_sck = sck_o; prev_cs = cs_n_o;
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (busy_o) n_busy++;
    if (!cs_n_o) n_csl++;
    if (prev_cs && !cs_n_o) t_cs = cyc;
    if (sck_o != prev_sck) begin
      if (n_tog == 0) t_first = cyc;
      else begin
        if (cyc - t_last < iv_min) iv_min = cyc - t_last;
        if (cyc - t_last > iv_max) iv_max = cyc - t_last;
      end
      t_last = cyc;
      n_tog++;
    end
    if (sample_o) begin
      n_samp++;
      if ((sck_o ^ exp_cpol) == exp_cpha) n_bad++;
    end
    if (shift_o) n_shift++;
    prev_sck = sck_o; prev_cs = cs_n_o;
  endtask

  task automatic run_xfer(input bit with_last);
    start_i = 1'b1; last_i = with_last;
    tick();
    start_i = 1'b0; last_i = 1'b0;
    for (int g = 0; g < 3000 && busy_o; g++) tick();
  endtask

  function automatic int per_of(input int d); return (d < 2) ? 2 : d; endfunction
  function automatic int dly_of(input int v, input int p); return (v == 0) ? p / 2 : v; endfunction

  task automatic set_cfg(input int div, input bit cpol, input bit cpha, input int code,
                         input int ds, input int dx, input int dc, input int mode);
    cfg_div = 8'(div); cfg_cpol = cpol; cfg_cpha = cpha; cfg_nbits = 4'(code);
    cfg_dly_sck = 8'(ds); cfg_dly_xfer = 8'(dx); cfg_dly_csh = 8'(dc); cfg_cs_mode = 2'(mode);
    exp_cpol = cpol; exp_cpha = cpha;
    for (int i = 0; i < 3; i++) tick();
  endtask

  task automatic t_reset();
    chk(cs_n_o == 1'b1, "R1 cs_n", int'(cs_n_o), 1);
    chk(sck_o == 1'b0, "R1 sck", int'(sck_o), 0);
    chk(!busy_o && !sample_o && !shift_o, "R1 busy/strobes",
        int'({busy_o, sample_o, shift_o}), 0);
  endtask

  // One released transfer in mode 2 with full timing checks.
  task automatic t_single(input int div, input bit cpol, input bit cpha, input int code,
                          input int ds, input int dc);
    int p, la, lb, n, d, c;
    p = per_of(div); la = p / 2; lb = p - la; n = code + 8;
    d = dly_of(ds, p); c = dly_of(dc, p);
    set_cfg(div, cpol, cpha, code, ds, 3, dc, 2);
    chk(sck_o == cpol, "R3 idle level before", int'(sck_o), int'(cpol));
    clr();
    run_xfer(1'b0);
    chk(n_tog == 2 * n, "R9 edge count", n_tog, 2 * n);
    chk(n_samp == n, "R13 sample count", n_samp, n);
    chk(n_shift == (cpha ? n : n - 1), "R13 shift count", n_shift, cpha ? n : n - 1);
    chk(n_bad == 0, "R4 sample edge role", n_bad, 0);
    chk(t_first - t_cs == (cpha ? d : d + la), "R5 R10 setup delay", t_first - t_cs,
        cpha ? d : d + la);
    chk(iv_min == la, "R2 short half", iv_min, la);
    chk(iv_max == lb, "R2 long half", iv_max, lb);
    chk(n_csl == d + n * p, "R7 cs low span", n_csl, d + n * p);
    chk(n_busy == d + n * p + c, "R7 R10 cs high hold", n_busy, d + n * p + c);
    chk(cs_n_o == 1'b1 && sck_o == cpol, "R8 R3 released mode 2",
        int'({cs_n_o, sck_o}), int'({1'b1, cpol}));
  endtask

  task automatic t_mode0();
    int n, p;
    p = 4; n = 8;
    set_cfg(4, 1'b0, 1'b0, 0, 2, 5, 3, 0);
    clr();
    start_i = 1'b1; tick(); start_i = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    start_i = 1'b1; tick(); start_i = 1'b0;   // ignored: busy
    for (int g = 0; g < 3000 && busy_o; g++) tick();
    chk(n_tog == 2 * n, "R12 start while busy ignored", n_tog, 2 * n);
    chk(n_busy == 2 + n * p + 5, "R6 gap after transfer", n_busy, 2 + n * p + 5);
    last_i = 1'b1; tick(); last_i = 1'b0;
    cfg_cpol = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    chk(cs_n_o == 1'b0 && !busy_o, "R8 mode 0 holds, last ignored",
        int'({cs_n_o, busy_o}), 0);
    chk(sck_o == 1'b0, "R11 polarity change held off", int'(sck_o), 0);
    clr();
    run_xfer(1'b0);
    chk(n_busy == n * p + 5, "R12 held start skips setup", n_busy, n * p + 5);
    chk(n_bad == 0 && n_tog == 2 * n, "R11 old config kept", n_bad, 0);
    clr();
    release_i = 1'b1; tick(); release_i = 1'b0;
    chk(cs_n_o == 1'b1, "R8 release in mode 0", int'(cs_n_o), 1);
    for (int g = 0; g < 100 && busy_o; g++) tick();
    chk(n_busy == 3, "R7 deselect time", n_busy, 3);
    tick(); tick();
    chk(sck_o == 1'b1, "R11 new polarity in idle", int'(sck_o), 1);
  endtask

  task automatic t_mode1();
    int n, p;
    p = 6; n = 10;
    set_cfg(6, 1'b1, 1'b1, 2, 0, 0, 4, 1);
    clr();
    run_xfer(1'b0);
    chk(n_busy == 3 + n * p + 3, "R6 R10 gap zero field", n_busy, 3 + n * p + 3);
    chk(cs_n_o == 1'b0, "R8 mode 1 holds without last", int'(cs_n_o), 0);
    clr();
    run_xfer(1'b1);
    chk(n_csl == n * p, "R8 mode 1 last releases", n_csl, n * p);
    chk(n_busy == n * p + 4, "R7 deselect after last", n_busy, n * p + 4);
    chk(cs_n_o == 1'b1 && sck_o == 1'b1, "R3 idle after release",
        int'({cs_n_o, sck_o}), 3);
    run_xfer(1'b0);
    last_i = 1'b1; tick(); last_i = 1'b0;
    chk(cs_n_o == 1'b1, "R8 mode 1 last while holding", int'(cs_n_o), 1);
    for (int g = 0; g < 100 && busy_o; g++) tick();
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    exp_cpol = 1'b0; exp_cpha = 1'b0;
    #35;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_single(4, 1'b0, 1'b0, 0, 3, 2);
    t_single(5, 1'b1, 1'b1, 15, 0, 7);
    t_single(0, 1'b0, 1'b1, 0, 1, 0);
    t_single(1, 1'b1, 1'b0, 1, 4, 1);
    t_single(7, 1'b1, 1'b0, 4, 10, 6);
    t_mode0();
    t_mode1();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule